// File: doc/BRIEF.md
# Bidirectional Host Data FIFO with Mode-Dependent Flags

This block is a 512 by 32-bit first-in first-out buffer between a codec core and a host bus. Its direction is set by a mode input. In encode mode the core pushes compressed words and the host pops them. In decode mode the host pushes words and the core pops them. Pushes and pops on the inactive side of the current direction are ignored. Changing the mode empties the buffer, so every direction starts clean.

Three flags describe the buffer, and their meaning follows the direction:

- **Stop** warns that the host must pause. In encode it means the buffer is empty. In decode it rises early, while 32 entries are still free.
- **Error** records a lost or invented word. It is sticky.
- **Service request** shows the half-full point.

A 16-bit register holds these flags, four event bits from neighbouring logic, and one interrupt enable per source. A single registered interrupt output combines them.

The host may move data 8, 16 or 32 bits at a time. Narrow transfers are packed into, or unpacked from, whole 32-bit words, least significant piece first.

Top module: `bidir_host_fifo`

## Requirements
- R1: While reset is held, every status bit, every enable bit, `irq`, `flag_stop`, `flag_err` and `flag_srq` read 0.
- R2: Encode mode (`mode_decode`=0). Words written on the core side are read on the host side in the same order. Host writes and core reads have no effect.
- R3: Decode mode (`mode_decode`=1). Words written on the host side are read on the core side in the same order. Host reads and core writes have no effect.
- R4: In encode mode, status bit 5 (`flag_stop`) is 1 exactly when the buffer held no word one clock earlier.
- R5: In decode mode, `flag_stop` is 1 exactly when the buffer held 480 or more words one clock earlier. The last 32 pushes stay safe.
- R6: Status bit 3 (`flag_srq`) is 1 when occupancy one clock earlier was 256 or more in encode mode, or 256 or fewer in decode mode.
- R7: Status bit 4 (`flag_err`) sets in the cycle after any of these events. The offending word is dropped.
  - Encode: a core push into a full buffer.
  - Decode: a core pop from an empty buffer.
  - Decode: a host word pushed into a full buffer.

  The bit stays set until a register write with bit 4 = 1 or a mode change.
- R8: A change of `mode_decode` empties the buffer and discards any partly packed or partly read word.
- R9: Host width code 0 selects 8-bit transfers, 1 selects 16-bit, and 2 or 3 select 32-bit. Narrow writes use only the low bits of `host_wdata`. They fill a word from its least significant byte or halfword upward. The word enters the buffer only after its last piece.
- R10: For narrow host reads, `host_rdata` carries the current piece of the oldest word, zero-extended, least significant piece first. The word leaves the buffer only after its last piece is read.
- R11: Status register layout:
  - Bit 0: video-data error.
  - Bit 1: statistics ready.
  - Bit 2: last code read.
  - Bit 6: memory error.
  - Bits 0, 1, 2 and 6 set on a pulse of their event input and clear when written with 1.
  - Bits 8 to 14 are the enables for status bits 0 to 6.
  - Bits 7 and 15 always read 0.
- R12: `irq` equals the OR over bits 0 to 6 of (status AND enable), as they stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_decode | input | 1 | 0 = encode (core fills), 1 = decode (host fills) |
| host_width | input | 2 | Host transfer width: 0 = 8, 1 = 16, 2/3 = 32 bits |
| host_wr | input | 1 | Host write strobe (decode only) |
| host_wdata | input | 32 | Host write data |
| host_rd | input | 1 | Host read strobe (encode only) |
| host_rdata | output | 32 | Current host read piece, zero-extended |
| core_wr | input | 1 | Core push strobe (encode only) |
| core_wdata | input | 32 | Core push data |
| core_rd | input | 1 | Core pop strobe (decode only) |
| core_rdata | output | 32 | Oldest word, shown ahead of the pop |
| ev_video_err | input | 1 | Video-data error event pulse |
| ev_stats_ready | input | 1 | Statistics ready event pulse |
| ev_last_code | input | 1 | Last code read event pulse |
| ev_mem_err | input | 1 | Memory error event pulse |
| reg_wr | input | 1 | Status/enable register write strobe |
| reg_wdata | input | 16 | Register write data: enables load, status bits clear on 1 |
| reg_rdata | output | 16 | Status and enable register read value |
| flag_stop | output | 1 | Stop flag (status bit 5) |
| flag_err | output | 1 | Error flag (status bit 4) |
| flag_srq | output | 1 | Service request flag (status bit 3) |
| irq | output | 1 | Combined interrupt |

## Verification
The occupancy counter is the only state behind the stop and service-request flags. If it is off by one, a flag moves one word early or late, and this shows two clocks after the push that crosses a threshold. The bench therefore steps one word at a time across 255/256/257 and across 479/480.

A wrong read or write pointer shows up as a mismatch on the first word read after the damage. Every filled word is read back across a full 512-entry cycle in both directions.

A lane counter out of step shows as a rotated or zero-padded word on the first completed narrow transfer. A partial word that reaches the buffer by mistake is caught at once, because an extra core pop in decode mode would not underflow.

// File: rtl/hfifo_pkg.sv
package hfifo_pkg;
  localparam int WORD_W = 32;
  localparam int NSRC   = 7;
  localparam int EN_LSB = 8;

  localparam int ST_VID  = 0;
  localparam int ST_STAT = 1;
  localparam int ST_LAST = 2;
  localparam int ST_SRQ  = 3;
  localparam int ST_ERR  = 4;
  localparam int ST_STOP = 5;
  localparam int ST_MEM  = 6;

  typedef enum logic [1:0] {
    HW_8   = 2'd0,
    HW_16  = 2'd1,
    HW_32  = 2'd2,
    HW_32B = 2'd3
  } hwidth_e;

  // index of the final host transfer within one word
  function automatic logic [1:0] last_lane(input logic [1:0] w);
    case (w)
      HW_8:    return 2'd3;
      HW_16:   return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] insert_piece(input logic [WORD_W-1:0] acc,
                                                     input logic [WORD_W-1:0] d,
                                                     input logic [1:0] lane,
                                                     input logic [1:0] w);
    logic [WORD_W-1:0] r;
    r = acc;
    case (w)
      HW_8:    r[int'(lane)*8 +: 8] = d[7:0];
      HW_16:   r[int'(lane[0])*16 +: 16] = d[15:0];
      default: r = d;
    endcase
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] extract_piece(input logic [WORD_W-1:0] word,
                                                      input logic [1:0] lane,
                                                      input logic [1:0] w);
    logic [WORD_W-1:0] r;
    r = '0;
    case (w)
      HW_8:    r[7:0]  = word[int'(lane)*8 +: 8];
      HW_16:   r[15:0] = word[int'(lane[0])*16 +: 16];
      default: r = word;
    endcase
    return r;
  endfunction

  function automatic logic stop_cond(input logic dec, input int occ,
                                     input int depth, input int margin);
    return dec ? (occ >= depth - margin) : (occ == 0);
  endfunction

  function automatic logic srq_cond(input logic dec, input int occ, input int depth);
    return dec ? (occ <= depth / 2) : (occ >= depth / 2);
  endfunction
endpackage

// File: rtl/hfifo_store.sv
module hfifo_store #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty,
  output logic             ovf_evt,
  output logic             udf_evt
);
  // DEPTH is a power of two so the pointers wrap naturally
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign ovf_evt = push && full;
  assign udf_evt = pop && empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r2_occ_step: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (count == $past(count) || count == $past(count) + CW'(1) ||
                count + CW'(1) == $past(count)));
  a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0);
endmodule

// File: rtl/hfifo_pack.sv
module hfifo_pack
  import hfifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [1:0]        width,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] head,
  input  logic              src_empty,
  output logic              push_req,
  output logic [WORD_W-1:0] push_word,
  output logic              pop_req,
  output logic [WORD_W-1:0] rd_piece
);
  logic [1:0] wlane, rlane;
  logic [WORD_W-1:0] acc, merged;
  logic wlast, rlast, rd_ok;

  assign merged    = insert_piece(acc, wr_data, wlane, width);
  assign wlast     = (wlane == last_lane(width));
  assign push_req  = wr_en && wlast;
  assign push_word = merged;

  assign rd_ok    = rd_en && !src_empty;
  assign rlast    = (rlane == last_lane(width));
  assign pop_req  = rd_ok && rlast;
  assign rd_piece = extract_piece(head, rlane, width);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlane <= '0;
      rlane <= '0;
      acc   <= '0;
    end else if (flush) begin
      wlane <= '0;
      rlane <= '0;
      acc   <= '0;
    end else begin
      if (wr_en) begin
        if (wlast) begin
          wlane <= '0;
          acc   <= '0;
        end else begin
          wlane <= wlane + 2'd1;
          acc   <= merged;
        end
      end
      if (rd_ok) rlane <= rlast ? 2'd0 : rlane + 2'd1;
    end
  end
endmodule

// File: rtl/hfifo_stat.sv
module hfifo_stat
  import hfifo_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [NSRC-1:0] evt,
  input  logic            live_srq,
  input  logic            live_stop,
  input  logic            reg_wr,
  input  logic [15:0]     reg_wdata,
  output logic [15:0]     reg_rdata,
  output logic [NSRC-1:0] stat_q,
  output logic            irq
);
  localparam logic [NSRC-1:0] LIVE_MASK = NSRC'((1 << ST_SRQ) | (1 << ST_STOP));
  localparam logic [NSRC-1:0] ERR_MASK  = NSRC'(1 << ST_ERR);

  logic [NSRC-1:0] en_q, w1c, sticky_nxt, live_vec, stat_d;
  logic pend;

  assign w1c        = reg_wr ? reg_wdata[NSRC-1:0] : '0;
  assign sticky_nxt = (stat_q & ~w1c & ~(flush ? ERR_MASK : '0)) | (evt & ~LIVE_MASK);
  always_comb begin
    live_vec = '0;
    live_vec[ST_SRQ]  = live_srq;
    live_vec[ST_STOP] = live_stop;
  end
  assign stat_d    = (sticky_nxt & ~LIVE_MASK) | live_vec;
  assign pend      = |(stat_q & en_q);
  assign reg_rdata = {1'b0, en_q, 1'b0, stat_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= stat_d;
      if (reg_wr) en_q <= reg_wdata[EN_LSB +: NSRC];
      irq <= pend;
    end
  end

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[ST_ERR] && !(reg_wr && reg_wdata[ST_ERR]) && !flush) |=> stat_q[ST_ERR]);
  a_r12_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> irq);
  a_r12_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> !irq);
endmodule

// File: rtl/bidir_host_fifo.sv
module bidir_host_fifo
  import hfifo_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int MARGIN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_decode,
  input  logic [1:0]  host_width,
  input  logic        host_wr,
  input  logic [31:0] host_wdata,
  input  logic        host_rd,
  output logic [31:0] host_rdata,
  input  logic        core_wr,
  input  logic [31:0] core_wdata,
  input  logic        core_rd,
  output logic [31:0] core_rdata,
  input  logic        ev_video_err,
  input  logic        ev_stats_ready,
  input  logic        ev_last_code,
  input  logic        ev_mem_err,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        flag_stop,
  output logic        flag_err,
  output logic        flag_srq,
  output logic        irq
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic mode_q, mode_chg;
  logic pk_push, pk_pop;
  logic [WORD_W-1:0] pk_word, pk_piece, head;
  logic st_push, st_pop, st_full, st_empty, ovf_evt, udf_evt;
  logic [WORD_W-1:0] st_data;
  logic [CW-1:0] occ;
  logic err_evt, stop_now, srq_now;
  logic [NSRC-1:0] evt, stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_decode;
  end
  assign mode_chg = mode_decode ^ mode_q;

  hfifo_pack u_pack (
    .clk(clk), .rst_n(rst_n), .flush(mode_chg), .width(host_width),
    .wr_en(host_wr && mode_decode), .wr_data(host_wdata),
    .rd_en(host_rd && !mode_decode), .head(head), .src_empty(st_empty),
    .push_req(pk_push), .push_word(pk_word), .pop_req(pk_pop), .rd_piece(pk_piece)
  );

  assign st_push = mode_decode ? pk_push : core_wr;
  assign st_data = mode_decode ? pk_word : core_wdata;
  assign st_pop  = mode_decode ? core_rd : pk_pop;

  hfifo_store #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(mode_chg),
    .push(st_push), .push_data(st_data), .pop(st_pop),
    .head(head), .count(occ), .full(st_full), .empty(st_empty),
    .ovf_evt(ovf_evt), .udf_evt(udf_evt)
  );

  assign err_evt  = !mode_chg && (mode_decode ? (ovf_evt || udf_evt) : ovf_evt);
  assign stop_now = stop_cond(mode_decode, int'(occ), DEPTH, MARGIN);
  assign srq_now  = srq_cond(mode_decode, int'(occ), DEPTH);

  always_comb begin
    evt = '0;
    evt[ST_VID]  = ev_video_err;
    evt[ST_STAT] = ev_stats_ready;
    evt[ST_LAST] = ev_last_code;
    evt[ST_ERR]  = err_evt;
    evt[ST_MEM]  = ev_mem_err;
  end

  hfifo_stat u_stat (
    .clk(clk), .rst_n(rst_n), .flush(mode_chg), .evt(evt),
    .live_srq(srq_now), .live_stop(stop_now),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .stat_q(stat_q), .irq(irq)
  );

  assign flag_stop  = stat_q[ST_STOP];
  assign flag_err   = stat_q[ST_ERR];
  assign flag_srq   = stat_q[ST_SRQ];
  assign host_rdata = pk_piece;
  assign core_rdata = head;

  // R5: a clear stop flag in decode leaves room for the next push and one more
  a_r5_stop_margin: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_decode && mode_q && !flag_stop && !mode_chg) |=> !st_full);
endmodule

// File: tb/sim_bidir_host_fifo.sv
`timescale 1ns/100ps
module sim_bidir_host_fifo;
  logic clk = 1'b0;
  logic rst_n;
  logic mode_decode;
  logic [1:0] host_width;
  logic host_wr, host_rd, core_wr, core_rd, reg_wr;
  logic [31:0] host_wdata, core_wdata, host_rdata, core_rdata;
  logic ev_video_err, ev_stats_ready, ev_last_code, ev_mem_err;
  logic [15:0] reg_wdata, reg_rdata;
  logic flag_stop, flag_err, flag_srq, irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bidir_host_fifo u0 (
    .clk(clk), .rst_n(rst_n), .mode_decode(mode_decode), .host_width(host_width),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .core_wr(core_wr), .core_wdata(core_wdata), .core_rd(core_rd), .core_rdata(core_rdata),
    .ev_video_err(ev_video_err), .ev_stats_ready(ev_stats_ready),
    .ev_last_code(ev_last_code), .ev_mem_err(ev_mem_err),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flag_stop(flag_stop), .flag_err(flag_err), .flag_srq(flag_srq), .irq(irq)
  );

  function automatic logic [31:0] wval(input int i);
    return (i * 32'h0100_0193) ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic settle;
    tick;
    tick;
  endtask

  task automatic core_put(input logic [31:0] d);
    core_wr = 1'b1; core_wdata = d; tick; core_wr = 1'b0;
  endtask

  task automatic core_take;
    core_rd = 1'b1; tick; core_rd = 1'b0;
  endtask

  task automatic host_put(input logic [31:0] d);
    host_wr = 1'b1; host_wdata = d; tick; host_wr = 1'b0;
  endtask

  task automatic host_take;
    host_rd = 1'b1; tick; host_rd = 1'b0;
  endtask

  task automatic reg_write(input logic [15:0] d);
    reg_wr = 1'b1; reg_wdata = d; tick; reg_wr = 1'b0;
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary;
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_decode = 1'b0; host_width = 2'd2;
    host_wr = 0; host_rd = 0; core_wr = 0; core_rd = 0; reg_wr = 0;
    host_wdata = '0; core_wdata = '0; reg_wdata = '0;
    ev_video_err = 0; ev_stats_ready = 0; ev_last_code = 0; ev_mem_err = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reg_rdata in reset", {16'h0, reg_rdata}, 32'h0);
    chk("R1 irq in reset", {31'h0, irq}, 32'h0);
    chk("R1 flags in reset", {29'h0, flag_stop, flag_err, flag_srq}, 32'h0);
    rst_n = 1'b1;
    settle;

    // ---------------- encode, 32-bit host ----------------
    chk("R4 stop when empty (encode)", {31'h0, flag_stop}, 32'h1);
    chk("R6 srq low when empty (encode)", {31'h0, flag_srq}, 32'h0);
    for (int i = 0; i < 255; i++) core_put(wval(i));
    settle;
    chk("R6 srq at 255 (encode)", {31'h0, flag_srq}, 32'h0);
    chk("R4 stop clear with data", {31'h0, flag_stop}, 32'h0);
    core_put(wval(255));
    settle;
    chk("R6 srq at 256 (encode)", {31'h0, flag_srq}, 32'h1);
    for (int i = 256; i < 512; i++) core_put(wval(i));
    // R2: wrong-side strobes in encode are ignored
    host_put(32'hDEAD_0001);
    core_take;
    settle;
    chk("R7 no error before overflow", {31'h0, flag_err}, 32'h0);
    core_put(32'hBAD0_BAD0);
    chk("R7 overflow sets error (encode)", {31'h0, flag_err}, 32'h1);
    chk("R7 error in status bit 4", {31'h0, reg_rdata[4]}, 32'h1);
    for (int i = 0; i < 512; i++) begin
      chk($sformatf("R2 encode order word %0d", i), host_rdata, wval(i));
      host_take;
    end
    settle;
    chk("R4 stop after drain (encode)", {31'h0, flag_stop}, 32'h1);
    chk("R7 error sticky", {31'h0, flag_err}, 32'h1);
    reg_write(16'h0010);
    chk("R7 write-one clears error", {31'h0, flag_err}, 32'h0);

    // ---------------- switch to decode ----------------
    for (int i = 0; i < 3; i++) core_put(wval(900 + i));
    reg_write(16'h1000);
    mode_decode = 1'b1;
    tick;
    core_take;
    chk("R8 flushed: underflow error", {31'h0, flag_err}, 32'h1);
    chk("R12 irq waits one clock", {31'h0, irq}, 32'h0);
    tick;
    chk("R12 irq after error", {31'h0, irq}, 32'h1);
    reg_write(16'h1010);
    chk("R7 cleared by write", {31'h0, flag_err}, 32'h0);
    chk("R12 irq still high one clock", {31'h0, irq}, 32'h1);
    tick;
    chk("R12 irq drops", {31'h0, irq}, 32'h0);
    chk("R6 srq high when empty (decode)", {31'h0, flag_srq}, 32'h1);
    for (int i = 0; i < 256; i++) host_put(wval(1000 + i));
    settle;
    chk("R6 srq at 256 (decode)", {31'h0, flag_srq}, 32'h1);
    host_put(wval(1256));
    settle;
    chk("R6 srq at 257 (decode)", {31'h0, flag_srq}, 32'h0);
    for (int i = 257; i < 479; i++) host_put(wval(1000 + i));
    settle;
    chk("R5 stop clear at 479", {31'h0, flag_stop}, 32'h0);
    host_put(wval(1479));
    settle;
    chk("R5 stop set at 480", {31'h0, flag_stop}, 32'h1);
    for (int i = 480; i < 512; i++) host_put(wval(1000 + i));
    settle;
    chk("R7 no error at exactly full", {31'h0, flag_err}, 32'h0);
    host_put(32'hBAD1_BAD1);
    chk("R7 host overflow sets error (decode)", {31'h0, flag_err}, 32'h1);
    reg_write(16'h1010);
    // R3: wrong-side strobes in decode are ignored
    host_take;
    core_put(32'hDEAD_0002);
    for (int i = 0; i < 512; i++) begin
      chk($sformatf("R3 decode order word %0d", i), core_rdata, wval(1000 + i));
      core_take;
    end
    settle;
    chk("R5 stop clear after drain", {31'h0, flag_stop}, 32'h0);
    chk("R7 no error during drain", {31'h0, flag_err}, 32'h0);

    // ---------------- narrow host writes (decode) ----------------
    host_width = 2'd0;
    host_put(32'hFFFF_FF11);
    host_put(32'hFFFF_FF22);
    host_put(32'hFFFF_FF33);
    core_take;
    chk("R9 partial word not pushed", {31'h0, flag_err}, 32'h1);
    reg_write(16'h1010);
    host_put(32'hFFFF_FF44);
    chk("R9 byte packing", core_rdata, 32'h4433_2211);
    core_take;
    host_width = 2'd1;
    host_put(32'h1234_BEEF);
    host_put(32'h5678_DEAD);
    chk("R9 halfword packing", core_rdata, 32'hDEAD_BEEF);
    core_take;

    // ---------------- narrow host reads (encode) ----------------
    mode_decode = 1'b0;
    host_width = 2'd0;
    tick;
    core_put(32'h89AB_CDEF);
    chk("R10 byte 0", host_rdata, 32'h0000_00EF);
    host_take;
    chk("R10 byte 1", host_rdata, 32'h0000_00CD);
    host_take;
    chk("R10 byte 2", host_rdata, 32'h0000_00AB);
    host_take;
    settle;
    chk("R10 word kept until last piece", {31'h0, flag_stop}, 32'h0);
    chk("R10 byte 3", host_rdata, 32'h0000_0089);
    host_take;
    settle;
    chk("R10 word popped after last piece", {31'h0, flag_stop}, 32'h1);
    host_width = 2'd1;
    core_put(32'h0BAD_F00D);
    chk("R10 half 0", host_rdata, 32'h0000_F00D);
    host_take;
    chk("R10 half 1", host_rdata, 32'h0000_0BAD);
    host_take;

    // ---------------- event sources and register layout ----------------
    reg_write(16'h4100);
    ev_mem_err = 1'b1; tick; ev_mem_err = 1'b0;
    chk("R11 memory error bit 6", {31'h0, reg_rdata[6]}, 32'h1);
    chk("R12 irq not yet", {31'h0, irq}, 32'h0);
    tick;
    chk("R12 irq from memory error", {31'h0, irq}, 32'h1);
    ev_video_err = 1'b1; ev_stats_ready = 1'b1; ev_last_code = 1'b1;
    tick;
    ev_video_err = 1'b0; ev_stats_ready = 1'b0; ev_last_code = 1'b0;
    tick;
    chk("R11 full register image", {16'h0, reg_rdata}, 32'h0000_4167);
    reg_write(16'hFFFF);
    chk("R11 clear and reserved bits", {16'h0, reg_rdata}, 32'h0000_7F20);
    tick;
    chk("R12 irq from stop enable", {31'h0, irq}, 32'h1);

    summary;
    $finish;
  end
endmodule